// File: doc/BRIEF.md
# Configurable FIR Final-Summation Adder

This block reduces N signed product terms, as delivered by the multiplier bank of an FIR filter, to one signed result. The terms arrive together on a flat vector, qualified by a valid strobe. A compile-time mode parameter picks the structure. The chain structure adds the terms one after another. The tree structure adds neighbouring pairs in parallel, level after level. The pipelined tree is the same tree with a register rank after every level, so it trades latency for a short adder path per cycle.

Every two-input adder clamps its result to a signed accumulator width. Because of this, the chain and the tree can give different answers once an intermediate sum saturates. The output valid follows the data through exactly as many registers as the data path has. A new set of terms may be presented on every cycle in all three modes.

Top module: `fir_final_sum`

## Requirements
- R1: In chain mode (MODE = 0) the result is ((t0 + t1) + t2) + ... + t(N-1), adding terms in ascending index order, with every partial sum saturated.
- R2: In tree mode (MODE = 1) each level adds neighbours (2j, 2j+1) of the previous level. An odd last operand passes unchanged to the next level. This repeats until one value remains.
- R3: Pipelined mode (MODE = 2) gives the same value as tree mode for the same terms.
- R4: out_valid and the matching out_sum appear 1 cycle after the edge that samples in_valid in chain and tree modes, and 1 + ceil(log2 N) cycles after it in pipelined mode.
- R5: Every adder output saturates to the signed ACC_W range [-2^(ACC_W-1), 2^(ACC_W-1)-1].
- R6: out_valid is high for exactly one cycle per accepted input set, and is low in every other cycle.
- R7: While out_valid is low, out_sum holds the last produced result.
- R8: While rst_n is low, out_valid and out_sum are 0, and reset takes effect without waiting for a clock edge.
- R9: Term i is the two's-complement field in_terms[i*IN_W +: IN_W], and it is sign-extended to ACC_W before it is summed.
- R10: Input sets on consecutive cycles are all accepted, and each produces its own result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_terms in this cycle |
| in_terms | input | N*IN_W | N signed product terms, term i at bits i*IN_W upward |
| out_valid | output | 1 | out_sum carries a new result this cycle |
| out_sum | output | ACC_W | Saturated signed sum |

## Verification
A wrong adder pairing or a wrong summation order shows up at out_sum only when it changes the value. The most revealing inputs are vectors in which an intermediate sum saturates. With such a vector the chain and the tree disagree, and the error appears in the same cycle the result is due. A fault in the valid or register alignment shows at the port within ceil(log2 N)+1 cycles: out_valid is high in the wrong cycle, or out_sum belongs to a neighbouring input set. Back-to-back streams make this visible at once. If the hold path is broken, out_sum drifts on the first idle cycle after a result.

// File: rtl/fsum_pkg.sv
package fsum_pkg;

  typedef enum logic [1:0] {
    SUM_CHAIN = 2'd0,
    SUM_TREE  = 2'd1,
    SUM_PIPE  = 2'd2
  } sum_mode_e;

  // operands remaining at tree level lv: ceil(n / 2^lv)
  function automatic int level_cnt(input int n, input int lv);
    return (n + (1 << lv) - 1) >> lv;
  endfunction

endpackage

// File: rtl/fsum_sat_add.sv
module fsum_sat_add #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);

  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] wide;

  assign wide = {a[W-1], a} + {b[W-1], b};

  always_comb begin
    if (wide[W] ^ wide[W-1]) begin
      y = wide[W] ? NEG_MIN : POS_MAX;
    end else begin
      y = wide[W-1:0];
    end
  end

endmodule

// File: rtl/fsum_chain.sv
module fsum_chain #(
  parameter int N = 8,
  parameter int W = 20
) (
  input  logic [N*W-1:0]      ops,
  output logic signed [W-1:0] sum
);

  logic signed [W-1:0] part [N];

  assign part[0] = ops[W-1:0];

  for (genvar i = 1; i < N; i++) begin : g_link
    fsum_sat_add #(.W(W)) u_add (
      .a (part[i-1]),
      .b (ops[i*W +: W]),
      .y (part[i])
    );
  end

  assign sum = part[N-1];

endmodule

// File: rtl/fsum_tree.sv
module fsum_tree #(
  parameter int N    = 8,
  parameter int W    = 20,
  parameter bit PIPE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [N*W-1:0]      ops,
  output logic                out_valid,
  output logic signed [W-1:0] out_sum
);

  localparam int LV = $clog2(N);

  for (genvar lv = 0; lv <= LV; lv++) begin : g_lvl
    localparam int CNT = fsum_pkg::level_cnt(N, lv);
    logic signed [W-1:0] q [CNT];
    logic                v;

    if (lv == 0) begin : g_in
      for (genvar j = 0; j < CNT; j++) begin : g_ld
        assign q[j] = ops[j*W +: W];
      end
      assign v = in_valid;
    end else begin : g_op
      localparam int PCNT = fsum_pkg::level_cnt(N, lv - 1);
      logic signed [W-1:0] nxt [CNT];

      for (genvar j = 0; j < CNT; j++) begin : g_node
        if (2*j + 1 < PCNT) begin : g_pair
          fsum_sat_add #(.W(W)) u_add (
            .a (g_lvl[lv-1].q[2*j]),
            .b (g_lvl[lv-1].q[2*j+1]),
            .y (nxt[j])
          );
        end else begin : g_pass
          assign nxt[j] = g_lvl[lv-1].q[2*j];
        end
      end

      if (PIPE) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v <= 1'b0;
            for (int k = 0; k < CNT; k++) q[k] <= '0;
          end else begin
            v <= g_lvl[lv-1].v;
            if (g_lvl[lv-1].v) begin
              for (int k = 0; k < CNT; k++) q[k] <= nxt[k];
            end
          end
        end
      end else begin : g_wire
        assign q = nxt;
        assign v = g_lvl[lv-1].v;
      end
    end
  end

  logic signed [W-1:0] sum_d, sum_q;
  logic                vld_q;

  always_comb begin
    sum_d = g_lvl[LV].v ? g_lvl[LV].q[0] : sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      vld_q <= g_lvl[LV].v;
    end
  end

  assign out_sum   = sum_q;
  assign out_valid = vld_q;

endmodule

// File: rtl/fir_final_sum.sv
module fir_final_sum #(
  parameter int                  N     = 8,
  parameter int                  IN_W  = 16,
  parameter int                  ACC_W = 20,
  parameter fsum_pkg::sum_mode_e MODE  = fsum_pkg::SUM_CHAIN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N*IN_W-1:0]       in_terms,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_sum
);

  localparam int LV  = $clog2(N);
  localparam int LAT = (MODE == fsum_pkg::SUM_PIPE) ? LV + 1 : 1;

  // R9: sign-extend each term to the accumulator width
  logic [N*ACC_W-1:0] ext;

  for (genvar i = 0; i < N; i++) begin : g_ext
    assign ext[i*ACC_W +: ACC_W] = ACC_W'($signed(in_terms[i*IN_W +: IN_W]));
  end

  if (MODE == fsum_pkg::SUM_CHAIN) begin : g_chain
    logic signed [ACC_W-1:0] res, sum_d, sum_q;
    logic                    vld_q;

    fsum_chain #(.N(N), .W(ACC_W)) u_chain (
      .ops (ext),
      .sum (res)
    );

    always_comb begin
      sum_d = in_valid ? res : sum_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
        vld_q <= 1'b0;
      end else begin
        sum_q <= sum_d;
        vld_q <= in_valid;
      end
    end

    assign out_sum   = sum_q;
    assign out_valid = vld_q;
  end else begin : g_tree
    fsum_tree #(.N(N), .W(ACC_W), .PIPE(MODE == fsum_pkg::SUM_PIPE)) u_tree (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .ops       (ext),
      .out_valid (out_valid),
      .out_sum   (out_sum)
    );
  end

  logic all_nonneg, all_neg;

  always_comb begin
    all_nonneg = 1'b1;
    all_neg    = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (in_terms[i*IN_W + IN_W - 1]) all_nonneg = 1'b0;
      else                              all_neg    = 1'b0;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, LAT)); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid, LAT) |-> $stable(out_sum)); // R7

  AST_POS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid, LAT) && $past(all_nonneg, LAT)) |-> !out_sum[ACC_W-1]); // R5

  AST_NEG_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid, LAT) && $past(all_neg, LAT)) |-> out_sum[ACC_W-1]); // R5

endmodule

// File: tb/sim_fir_final_sum.sv
module sim_fir_final_sum;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 5;
  localparam int IN_W       = 4;
  localparam int ACC_W      = 5;
  localparam int LV         = 3;
  localparam int LSB_MARGIN = 0;
  localparam int SMAX       = (1 << (ACC_W - 1)) - 1;
  localparam int SMIN       = -(1 << (ACC_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N*IN_W-1:0] in_terms = '0;

  logic ov0, ov1, ov2;
  logic signed [ACC_W-1:0] os0, os1, os2;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_final_sum #(.N(N), .IN_W(IN_W), .ACC_W(ACC_W), .MODE(fsum_pkg::SUM_CHAIN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_terms(in_terms),
    .out_valid(ov0), .out_sum(os0));
  fir_final_sum #(.N(N), .IN_W(IN_W), .ACC_W(ACC_W), .MODE(fsum_pkg::SUM_TREE)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_terms(in_terms),
    .out_valid(ov1), .out_sum(os1));
  fir_final_sum #(.N(N), .IN_W(IN_W), .ACC_W(ACC_W), .MODE(fsum_pkg::SUM_PIPE)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_terms(in_terms),
    .out_valid(ov2), .out_sum(os2));

  int  errors = 0;
  int  checks = 0;
  int  m = 0;
  bit  done = 1'b0;
  int  seed = 32'h1234_5678;
  bit  h_v [16];
  int  h_c [16];
  int  h_t [16];
  int  last0 = 0, last1 = 0, last2 = 0;
  string phase = "idle";

  function automatic int sat(input int v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  // R1: ascending-index chain, saturating each partial sum
  function automatic int chain_ref(input int t [N]);
    int acc = t[0];
    for (int i = 1; i < N; i++) acc = sat(acc + t[i]);
    return acc;
  endfunction

  // R2: neighbour pairs per level, odd last operand forwarded
  function automatic int tree_ref(input int t [N]);
    int cur [N];
    int cnt = N;
    cur = t;
    while (cnt > 1) begin
      for (int j = 0; j < (cnt + 1) / 2; j++) begin
        if (2*j + 1 < cnt) cur[j] = sat(cur[2*j] + cur[2*j+1]);
        else               cur[j] = cur[2*j];
      end
      cnt = (cnt + 1) / 2;
    end
    return cur[0];
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  task automatic fail_line(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
  endtask

  task automatic chk(input string name, input int d, input logic ov, input int os,
                     input bit use_tree, inout int last);
    int  idx;
    bit  ev;
    int  e;
    idx = m - d;
    ev  = (idx >= 0) && h_v[idx % 16];
    checks++;
    if (ov !== ev) fail_line({"R4/R6/R10 valid ", name}, int'(ov), int'(ev));
    checks++;
    if (ev) begin
      e    = use_tree ? h_t[idx % 16] : h_c[idx % 16];
      last = e;
      if ((os >>> LSB_MARGIN) != (e >>> LSB_MARGIN))
        fail_line(use_tree ? {"R2/R3/R5/R9 sum ", name} : {"R1/R5/R9 sum ", name}, os, e);
    end else if (os != last) begin
      fail_line({"R7 hold ", name}, os, last);
    end
  endtask

  task automatic step(input bit v, input int t [N]);
    @(negedge clk);
    chk("chain", 1, ov0, int'(os0), 1'b0, last0);
    chk("tree", 1, ov1, int'(os1), 1'b1, last1);
    chk("pipe", LV + 1, ov2, int'(os2), 1'b1, last2);
    in_valid = v;
    for (int i = 0; i < N; i++) in_terms[i*IN_W +: IN_W] = t[i][IN_W-1:0];
    h_v[m % 16] = v;
    h_c[m % 16] = chain_ref(t);
    h_t[m % 16] = tree_ref(t);
    m++;
  endtask

  task automatic rand_terms(output int t [N]);
    bit ext_pick;
    ext_pick = (rnd() % 4) == 0;
    for (int i = 0; i < N; i++) begin
      if (ext_pick) begin
        case (rnd() % 4)
          0: t[i] = -8;
          1: t[i] = 7;
          2: t[i] = 0;
          default: t[i] = -1;
        endcase
      end else begin
        t[i] = (rnd() % 16) - 8;
      end
    end
  endtask

  task automatic check_reset_outputs();
    checks++;
    if (ov0 !== 1'b0 || ov1 !== 1'b0 || ov2 !== 1'b0)
      fail_line("R8 valid in reset", int'(ov0) + int'(ov1) + int'(ov2), 0);
    checks++;
    if (os0 !== '0 || os1 !== '0 || os2 !== '0)
      fail_line("R8 sum in reset", int'(os0) | int'(os1) | int'(os2), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int t [N];
    repeat (3) @(negedge clk);
    check_reset_outputs();
    rst_n = 1'b1;
    m = 0;
    last0 = 0; last1 = 0; last2 = 0;

    phase = "idle after reset R8";
    for (int i = 0; i < N; i++) t[i] = 0;
    repeat (6) step(1'b0, t);

    phase = "directed extremes R5";
    for (int i = 0; i < N; i++) t[i] = 7;
    step(1'b1, t);
    repeat (6) step(1'b0, t);
    for (int i = 0; i < N; i++) t[i] = -8;
    step(1'b1, t);
    repeat (6) step(1'b0, t);
    // chain gives -1, tree gives 5 with ACC_W = 5: order matters under saturation
    t = '{7, 7, 7, -8, -8};
    step(1'b1, t);
    repeat (6) step(1'b0, t);
    t = '{-8, 7, -8, 7, -8};
    step(1'b1, t);
    t = '{0, 0, 0, 0, 0};
    step(1'b1, t);
    t = '{1, -1, 2, -2, 3};
    step(1'b1, t);
    repeat (6) step(1'b0, t);

    phase = "back-to-back R10";
    for (int k = 0; k < 300; k++) begin
      rand_terms(t);
      step(1'b1, t);
    end

    phase = "random gaps R1 R2 R3";
    for (int k = 0; k < 2500; k++) begin
      rand_terms(t);
      step((rnd() % 2) == 1, t);
    end

    phase = "mid-run reset R8";
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check_reset_outputs();
    repeat (3) @(negedge clk);
    check_reset_outputs();
    rst_n = 1'b1;
    m = 0;
    last0 = 0; last1 = 0; last2 = 0;

    phase = "after reset R10";
    for (int k = 0; k < 40; k++) begin
      rand_terms(t);
      step(1'b1, t);
    end
    for (int i = 0; i < N; i++) t[i] = 0;
    repeat (8) step(1'b0, t);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule